// File: doc/BRIEF.md
# Layer Window Alpha Blender

This block places one RGB565 picture layer on top of a flat background colour for a raster display pipeline. Every pixel clock it receives the current screen coordinate and data-enable from the display timing generator together with the layer pixel for that coordinate. If the coordinate lies inside a programmable rectangle and the layer is switched on, the layer pixel is mixed over the background. Otherwise the layer's 32-bit ARGB default colour is mixed over the background instead.

The mixing weight is the pixel alpha multiplied by an 8-bit constant alpha. An RGB565 pixel always carries alpha 0xFF. The background receives the complement of that weight. The rectangle limits are written in absolute timing coordinates, so a visible column c is programmed as c + 1 + accumulated horizontal back porch, and rows follow the same rule with the vertical back porch. The result leaves as 24-bit RGB, with data-enable and coordinates delayed by the same two cycles.

Top module: `layer_win_blend`

## Requirements
- R1: During and directly after reset, de_out, hpos_out, vpos_out and rgb_out are all zero.
- R2: de_out, hpos_out and vpos_out equal de_in, hpos_in and vpos_in from two clock cycles earlier, and rgb_out belongs to that same delayed pixel.
- R3: A coordinate is inside the window when hwin_cfg[11:0] <= hpos <= hwin_cfg[27:16] and vwin_cfg[10:0] <= vpos <= vwin_cfg[26:16]; both limits are inclusive.
- R4: An RGB565 pixel (red in bits 15:11, green in 10:5, blue in 4:0) is widened to 8 bits per channel by copying its top bits into the freed low bits, and its alpha is taken as 0xFF.
- R5: Inside the window with the layer on, each output channel is round-to-nearest of (F*L + (65025-F)*B) / 65025, where F = 255 * const_alpha, L is the widened layer channel and B the background channel.
- R6: Outside the window, the same formula is used with L taken from dflt_argb[23:0] (red 23:16, green 15:8, blue 7:0) and F = dflt_argb[31:24] * const_alpha.
- R7: layer_ctl bit 0 switches the layer on; when it is clear the default colour is used everywhere, and the other bits of layer_ctl (including bits 1 and 4) have no effect.
- R8: The layer is used only when pix_fmt equals 2 (RGB565); any other format code gives the default-colour result of R6 inside the window too.
- R9: While de_out is low, rgb_out is zero.
- R10: A weight of zero (const_alpha = 0, or default alpha 0 outside the window) makes rgb_out equal bg_rgb exactly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| de_in | input | 1 | Data-enable from the timing generator |
| hpos_in | input | 12 | Absolute horizontal timing coordinate |
| vpos_in | input | 11 | Absolute vertical timing coordinate |
| pix_in | input | 16 | Layer pixel, RGB565 |
| hwin_cfg | input | 32 | Window columns: first in bits 11:0, last in bits 27:16 |
| vwin_cfg | input | 32 | Window rows: first in bits 10:0, last in bits 26:16 |
| layer_ctl | input | 8 | Layer control, bit 0 enables the layer |
| pix_fmt | input | 3 | Layer pixel format code, 2 = RGB565 |
| const_alpha | input | 8 | Constant alpha, 0xFF opaque |
| dflt_argb | input | 32 | Layer default colour with alpha in bits 31:24 |
| bg_rgb | input | 24 | Background colour |
| de_out | output | 1 | Delayed data-enable |
| hpos_out | output | 12 | Delayed horizontal coordinate |
| vpos_out | output | 11 | Delayed vertical coordinate |
| rgb_out | output | 24 | Blended colour, red 23:16, green 15:8, blue 7:0 |

## Verification
A wrong window comparison shows up as the wrong colour on exactly the border columns or rows, two cycles after that coordinate enters; the bench therefore probes each of the four edges and the pixel just beyond it. A broken delay line shows as de_out or the coordinates misaligned with the data on the very first streamed pixels. Faults in the weight or the division stay hidden at alpha 0 and 0xFF and only surface at half-way alphas, so those are checked against hand-worked rounded values.

// File: rtl/lwb_pkg.sv
package lwb_pkg;

  localparam int CW    = 8;
  localparam int WW    = 16;
  localparam int UNITY = 255 * 255;
  localparam int HALF  = UNITY / 2;
  localparam int NW    = 25;
  localparam logic [2:0] FMT_RGB565 = 3'd2;

  typedef logic [3*CW-1:0] rgb_t;

  // RGB565 to 8:8:8 by repeating the most significant bits
  function automatic rgb_t widen565(input logic [15:0] p);
    logic [7:0] r, g, b;
    r = {p[15:11], p[15:13]};
    g = {p[10:5],  p[10:9]};
    b = {p[4:0],   p[4:2]};
    return {r, g, b};
  endfunction

  // weight from two 8-bit alphas
  function automatic logic [WW-1:0] weight_of(input logic [7:0] a, input logic [7:0] ca);
    return WW'(a) * WW'(ca);
  endfunction

  // one channel: (w*c + (UNITY-w)*b) / UNITY, rounded to nearest
  function automatic logic [CW-1:0] blend_ch(input logic [CW-1:0] c,
                                             input logic [CW-1:0] b,
                                             input logic [WW-1:0] w);
    logic [NW-1:0] num;
    logic [NW-1:0] quo;
    num = NW'(w) * NW'(c) + (NW'(UNITY) - NW'(w)) * NW'(b) + NW'(HALF);
    quo = num / NW'(UNITY);
    return quo[CW-1:0];
  endfunction

endpackage

// File: rtl/lwb_win_hit.sv
module lwb_win_hit #(
  parameter int HW = 12,
  parameter int VW = 11
) (
  input  logic [HW-1:0] hpos,
  input  logic [VW-1:0] vpos,
  input  logic [31:0]   hcfg,
  input  logic [31:0]   vcfg,
  output logic          hit
);
  localparam int STOP_LSB = 16;

  logic [HW-1:0] h_first, h_last;
  logic [VW-1:0] v_first, v_last;
  logic          h_in, v_in;

  assign h_first = hcfg[HW-1:0];
  assign h_last  = hcfg[STOP_LSB+HW-1:STOP_LSB];
  assign v_first = vcfg[VW-1:0];
  assign v_last  = vcfg[STOP_LSB+VW-1:STOP_LSB];

  assign h_in = (hpos >= h_first) && (hpos <= h_last);
  assign v_in = (vpos >= v_first) && (vpos <= v_last);
  assign hit  = h_in && v_in;
endmodule

// File: rtl/lwb_src_sel.sv
module lwb_src_sel
  import lwb_pkg::*;
(
  input  logic          hit,
  input  logic [7:0]    layer_ctl,
  input  logic [2:0]    pix_fmt,
  input  logic [15:0]   pix,
  input  logic [7:0]    const_alpha,
  input  logic [31:0]   dflt_argb,
  output rgb_t          src,
  output logic [WW-1:0] weight
);
  localparam logic [7:0] PIX_ALPHA = 8'hFF;

  logic layer_on;
  logic use_layer;

  assign layer_on  = layer_ctl[0] && (pix_fmt == FMT_RGB565);
  assign use_layer = layer_on && hit;

  always_comb begin
    if (use_layer) begin
      src    = widen565(pix);
      weight = weight_of(PIX_ALPHA, const_alpha);
    end else begin
      src    = dflt_argb[23:0];
      weight = weight_of(dflt_argb[31:24], const_alpha);
    end
  end
endmodule

// File: rtl/lwb_mixer.sv
module lwb_mixer
  import lwb_pkg::*;
(
  input  rgb_t          src,
  input  rgb_t          bg,
  input  logic [WW-1:0] weight,
  output rgb_t          mix
);
  for (genvar ch = 0; ch < 3; ch++) begin : g_ch
    assign mix[ch*CW +: CW] = blend_ch(src[ch*CW +: CW], bg[ch*CW +: CW], weight);
  end
endmodule

// File: rtl/layer_win_blend.sv
module layer_win_blend
  import lwb_pkg::*;
#(
  parameter int HW = 12,
  parameter int VW = 11
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          de_in,
  input  logic [HW-1:0] hpos_in,
  input  logic [VW-1:0] vpos_in,
  input  logic [15:0]   pix_in,
  input  logic [31:0]   hwin_cfg,
  input  logic [31:0]   vwin_cfg,
  input  logic [7:0]    layer_ctl,
  input  logic [2:0]    pix_fmt,
  input  logic [7:0]    const_alpha,
  input  logic [31:0]   dflt_argb,
  input  logic [23:0]   bg_rgb,
  output logic          de_out,
  output logic [HW-1:0] hpos_out,
  output logic [VW-1:0] vpos_out,
  output logic [23:0]   rgb_out
);
  // stage 0: window decision and source choice
  logic          win_hit;
  rgb_t          sel_src;
  logic [WW-1:0] sel_w;

  lwb_win_hit #(.HW(HW), .VW(VW)) u_hit (
    .hpos (hpos_in),
    .vpos (vpos_in),
    .hcfg (hwin_cfg),
    .vcfg (vwin_cfg),
    .hit  (win_hit)
  );

  lwb_src_sel u_sel (
    .hit         (win_hit),
    .layer_ctl   (layer_ctl),
    .pix_fmt     (pix_fmt),
    .pix         (pix_in),
    .const_alpha (const_alpha),
    .dflt_argb   (dflt_argb),
    .src         (sel_src),
    .weight      (sel_w)
  );

  // stage 1 registers
  logic          s1_de;
  logic [HW-1:0] s1_h;
  logic [VW-1:0] s1_v;
  rgb_t          s1_src;
  rgb_t          s1_bg;
  logic [WW-1:0] s1_w;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_de  <= 1'b0;
      s1_h   <= '0;
      s1_v   <= '0;
      s1_src <= '0;
      s1_bg  <= '0;
      s1_w   <= '0;
    end else begin
      s1_de  <= de_in;
      s1_h   <= hpos_in;
      s1_v   <= vpos_in;
      s1_src <= sel_src;
      s1_bg  <= bg_rgb;
      s1_w   <= sel_w;
    end
  end

  // stage 1 arithmetic
  rgb_t mix_rgb;

  lwb_mixer u_mix (
    .src    (s1_src),
    .bg     (s1_bg),
    .weight (s1_w),
    .mix    (mix_rgb)
  );

  // stage 2 registers (outputs)
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      de_out   <= 1'b0;
      hpos_out <= '0;
      vpos_out <= '0;
      rgb_out  <= '0;
    end else begin
      de_out   <= s1_de;
      hpos_out <= s1_h;
      vpos_out <= s1_v;
      rgb_out  <= s1_de ? mix_rgb : '0;
    end
  end
endmodule

// File: rtl/layer_win_blend_chk.sv
module layer_win_blend_chk #(
  parameter int HW = 12,
  parameter int VW = 11
) (
  input logic          clk,
  input logic          rst_n,
  input logic          de_in,
  input logic [HW-1:0] hpos_in,
  input logic [VW-1:0] vpos_in,
  input logic          de_out,
  input logic [HW-1:0] hpos_out,
  input logic [VW-1:0] vpos_out,
  input logic [23:0]   rgb_out,
  input logic          s1_de,
  input logic [15:0]   s1_w,
  input logic [23:0]   s1_src,
  input logic [23:0]   s1_bg
);
  logic [1:0] since_rst;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) since_rst <= 2'd0;
    else if (since_rst != 2'd2) since_rst <= since_rst + 2'd1;
  end

  assert_de_delay_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (since_rst == 2'd2) |-> (de_out == $past(de_in, 2)));

  assert_pos_delay_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (since_rst == 2'd2) |-> (hpos_out == $past(hpos_in, 2) && vpos_out == $past(vpos_in, 2)));

  assert_blank_black_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !de_out |-> (rgb_out == 24'h0));

  assert_full_weight_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (s1_de && s1_w == 16'd65025) |=> (rgb_out == $past(s1_src)));

  assert_zero_weight_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (s1_de && s1_w == 16'd0) |=> (rgb_out == $past(s1_bg)));
endmodule

bind layer_win_blend layer_win_blend_chk #(.HW(HW), .VW(VW)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .de_in    (de_in),
  .hpos_in  (hpos_in),
  .vpos_in  (vpos_in),
  .de_out   (de_out),
  .hpos_out (hpos_out),
  .vpos_out (vpos_out),
  .rgb_out  (rgb_out),
  .s1_de    (s1_de),
  .s1_w     (s1_w),
  .s1_src   (s1_src),
  .s1_bg    (s1_bg)
);

// File: tb/layer_win_blend_tb.sv
`timescale 1ns/1ps
module layer_win_blend_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        de_in = 1'b0;
  logic [11:0] hpos_in = '0;
  logic [10:0] vpos_in = '0;
  logic [15:0] pix_in = '0;
  logic [31:0] hwin_cfg = 32'h0013_000A;  // columns 10..19
  logic [31:0] vwin_cfg = 32'h0008_0005;  // rows 5..8
  logic [7:0]  layer_ctl = '0;
  logic [2:0]  pix_fmt = 3'd2;
  logic [7:0]  const_alpha = 8'hFF;
  logic [31:0] dflt_argb = '0;
  logic [23:0] bg_rgb = 24'h102030;
  logic        de_out;
  logic [11:0] hpos_out;
  logic [10:0] vpos_out;
  logic [23:0] rgb_out;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  layer_win_blend u_dut (
    .clk(clk), .rst_n(rst_n), .de_in(de_in), .hpos_in(hpos_in), .vpos_in(vpos_in),
    .pix_in(pix_in), .hwin_cfg(hwin_cfg), .vwin_cfg(vwin_cfg), .layer_ctl(layer_ctl),
    .pix_fmt(pix_fmt), .const_alpha(const_alpha), .dflt_argb(dflt_argb), .bg_rgb(bg_rgb),
    .de_out(de_out), .hpos_out(hpos_out), .vpos_out(vpos_out), .rgb_out(rgb_out)
  );

  typedef struct packed {
    logic [3:0]  req;
    logic        de;
    logic [11:0] h;
    logic [10:0] v;
    logic [15:0] pix;
    logic [7:0]  ctl;
    logic [2:0]  fmt;
    logic [7:0]  ca;
    logic [31:0] dflt;
    logic [23:0] exp;
  } vec_t;

  localparam int NV = 19;
  localparam vec_t VECS [NV] = '{
    '{4'd4,  1'b1, 12'd12, 11'd6, 16'hF800, 8'h01, 3'd2, 8'hFF, 32'h0,          24'hFF0000}, // R4 red
    '{4'd4,  1'b1, 12'd12, 11'd6, 16'h07E0, 8'h01, 3'd2, 8'hFF, 32'h0,          24'h00FF00}, // R4 green
    '{4'd4,  1'b1, 12'd12, 11'd6, 16'h001F, 8'h01, 3'd2, 8'hFF, 32'h0,          24'h0000FF}, // R4 blue
    '{4'd4,  1'b1, 12'd12, 11'd6, 16'h8410, 8'h01, 3'd2, 8'hFF, 32'h0,          24'h848284}, // R4 bit copy
    '{4'd3,  1'b1, 12'd10, 11'd5, 16'hFFFF, 8'h01, 3'd2, 8'hFF, 32'h0,          24'hFFFFFF}, // R3 first corner
    '{4'd3,  1'b1, 12'd19, 11'd8, 16'hFFFF, 8'h01, 3'd2, 8'hFF, 32'h0,          24'hFFFFFF}, // R3 last corner
    '{4'd3,  1'b1, 12'd9,  11'd6, 16'hFFFF, 8'h01, 3'd2, 8'hFF, 32'h0,          24'h102030}, // R3 left of window
    '{4'd3,  1'b1, 12'd20, 11'd6, 16'hFFFF, 8'h01, 3'd2, 8'hFF, 32'h0,          24'h102030}, // R3 right of window
    '{4'd3,  1'b1, 12'd12, 11'd4, 16'hFFFF, 8'h01, 3'd2, 8'hFF, 32'h0,          24'h102030}, // R3 above window
    '{4'd3,  1'b1, 12'd12, 11'd9, 16'hFFFF, 8'h01, 3'd2, 8'hFF, 32'h0,          24'h102030}, // R3 below window
    '{4'd6,  1'b1, 12'd30, 11'd6, 16'hFFFF, 8'h01, 3'd2, 8'hFF, 32'hFFAABBCC,   24'hAABBCC}, // R6 opaque default
    '{4'd10, 1'b1, 12'd12, 11'd6, 16'hFFFF, 8'h01, 3'd2, 8'h00, 32'h0,          24'h102030}, // R10 alpha zero
    '{4'd7,  1'b1, 12'd12, 11'd6, 16'hFFFF, 8'h00, 3'd2, 8'hFF, 32'h0,          24'h102030}, // R7 layer off
    '{4'd7,  1'b1, 12'd12, 11'd6, 16'hFFFF, 8'h12, 3'd2, 8'hFF, 32'h0,          24'h102030}, // R7 keying bits, layer off
    '{4'd7,  1'b1, 12'd12, 11'd6, 16'hF800, 8'h13, 3'd2, 8'hFF, 32'h0,          24'hFF0000}, // R7 extra bits ignored
    '{4'd8,  1'b1, 12'd12, 11'd6, 16'hFFFF, 8'h01, 3'd0, 8'hFF, 32'h0,          24'h102030}, // R8 other format
    '{4'd5,  1'b1, 12'd12, 11'd6, 16'hFFFF, 8'h01, 3'd2, 8'h80, 32'h0,          24'h889098}, // R5 half alpha
    '{4'd6,  1'b1, 12'd30, 11'd6, 16'hFFFF, 8'h01, 3'd2, 8'hFF, 32'h80000000,   24'h081018}, // R6 half default alpha
    '{4'd9,  1'b0, 12'd12, 11'd6, 16'hFFFF, 8'h01, 3'd2, 8'hFF, 32'h0,          24'h000000}  // R9 blanking
  };

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  endtask

  initial begin
    #2_000_000;
    n_chk++;
    n_fail++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: outputs in reset
    check("R1 de_out in reset", 32'(de_out), 32'd0);
    check("R1 rgb_out in reset", 32'(rgb_out), 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 after release", {19'd0, de_out, hpos_out}, 32'd0);
    check("R1 rgb after release", 32'(rgb_out), 32'd0);

    // table walk
    for (int i = 0; i < NV; i++) begin
      de_in = VECS[i].de; hpos_in = VECS[i].h; vpos_in = VECS[i].v;
      pix_in = VECS[i].pix; layer_ctl = VECS[i].ctl; pix_fmt = VECS[i].fmt;
      const_alpha = VECS[i].ca; dflt_argb = VECS[i].dflt;
      @(posedge clk); @(posedge clk); @(negedge clk);
      check($sformatf("R%0d vector %0d rgb", VECS[i].req, i), 32'(rgb_out), 32'(VECS[i].exp));
      check($sformatf("R2 vector %0d de/pos", i), {8'(de_out), hpos_out, vpos_out},
            {8'(VECS[i].de), VECS[i].h, VECS[i].v});
    end

    // R2: streamed pixels, each output two cycles behind its input
    layer_ctl = 8'h01; pix_fmt = 3'd2; const_alpha = 8'hFF; dflt_argb = 32'h0;
    for (int i = 0; i < 10; i++) begin
      de_in = i[0]; hpos_in = 12'(100 + i); vpos_in = 11'(i);
      pix_in = 16'hFFFF;
      if (i >= 2) begin
        check("R2 stream de", 32'(de_out), 32'((i - 2) % 2));
        check("R2 stream hpos", 32'(hpos_out), 32'(100 + i - 2));
        check("R2 stream vpos", 32'(vpos_out), 32'(i - 2));
        check("R9 stream blank/bg", 32'(rgb_out), ((i - 2) % 2 == 1) ? 32'h102030 : 32'h0);
      end
      @(negedge clk);
    end

    // R10: transparent default outside window on a new background
    de_in = 1'b1; hpos_in = 12'd50; vpos_in = 11'd50; bg_rgb = 24'h5A6B7C;
    dflt_argb = 32'h00FFFFFF;
    @(posedge clk); @(posedge clk); @(negedge clk);
    check("R10 zero default alpha", 32'(rgb_out), 32'h5A6B7C);

    // R1: reset in mid-stream clears outputs
    rst_n = 1'b0;
    #1;
    check("R1 mid-run reset", {7'd0, de_out, rgb_out}, 32'd0);
    finish_run();
  end

endmodule